// File: doc/BRIEF.md
# Index Prefix Decoder

This block sits at the front of an instruction decoder for an 8-bit processor. It accepts one opcode byte at a time, in fetch order. It tracks the two index-register prefixes and the extended-page prefix. From these it produces one descriptor per instruction. The descriptor tells the execution side four things:

- which index register applies;
- whether the memory operand formed through HL turns into an indexed memory operand;
- whether the H, L and HL register references are redirected to the index register;
- whether the displacement byte came before the final opcode byte, as it does on the indexed bit-manipulation page.

The input stream carries prefix, displacement and opcode bytes only. Immediate data bytes are fetched by the consumer and never reach this block. The decoder consumes a displacement byte itself and attaches it to the descriptor. A prefix that is overridden or cancelled by a later prefix produces a descriptor of its own, marked as a dropped prefix. The consumer counts it as a one-fetch no-operation, which keeps its refresh and timing counters moving. Both sides use a valid/ready handshake, and a single output register sits between them.

Top module: `index_prefix_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. No prefix state survives reset: a byte 0x7E fed right after reset is decoded with out_index = 0, even if a prefix was pending before reset.
- R2: An unprefixed byte that is not a prefix gives a descriptor when that byte is accepted. The descriptor has out_kind = 1 (main page), out_index = 0, out_opcode equal to the byte, and all flag outputs 0.
  - out_kind codes: 0 = dropped prefix, 1 = main page, 2 = extended page, 3 = bit page.
  - out_index codes: 0 = none, 1 = 0xDD register, 2 = 0xFD register.
- R3: Index prefixes (0xDD, 0xFD) can arrive back to back. Each later prefix makes the block emit a descriptor for the previous one, with out_kind = 0, out_index = 0 and out_opcode equal to the dropped prefix byte. Only the last prefix of the chain gives the index of the following instruction.
- R4: An indexed main-page opcode with a memory operand is held until the displacement byte that follows it arrives. The memory-operand opcodes are:
  - pattern 01yyyzzz with y = 6 or z = 6, except 0x76;
  - pattern 10yyy110;
  - 0x34, 0x35 and 0x36.

  The descriptor then has out_mem_idx = 1, out_has_disp = 1, out_disp equal to the displacement byte and out_disp_first = 0.
- R5: An indexed load of H or L from memory, or a store of H or L to memory (for example 0x66 or 0x74), indexes only the memory operand: out_mem_idx = 1 and out_reg_sub = 0.
- R6: An indexed main-page opcode without a memory operand is emitted at once with out_reg_sub = 1, out_mem_idx = 0 and out_has_disp = 0. The exceptions are 0xEB and 0xD9, which keep out_reg_sub = 0.
- R7: An index prefix followed by 0xED is dropped. A kind-0 descriptor for it appears when 0xED is accepted. The extended instruction that follows is reported with out_index = 0.
- R8: The byte after 0xED is taken as the extended opcode whatever its value, even if it is 0xDD, 0xFD, 0xCB or 0xED. It gives out_kind = 2 and out_opcode equal to that byte.
- R9: 0xCB without an index prefix makes the next byte a bit-page opcode: out_kind = 3, out_index = 0 and no displacement.
- R10: An index prefix, then 0xCB, then a displacement, then an opcode, gives a single descriptor when the opcode is accepted. The descriptor has out_kind = 3, the prefix's index, out_mem_idx = 1, out_has_disp = 1, out_disp_first = 1, out_disp equal to the displacement and out_opcode equal to the last byte.
- R11: All prefix state clears once a descriptor for an instruction has been produced. The next plain opcode is decoded with out_index = 0.
- R12: in_ready equals !out_valid || out_ready. While out_valid = 1 and out_ready = 0, the descriptor outputs hold their values and no input byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Decoder can accept a byte |
| in_byte | input | 8 | Fetched byte |
| out_valid | output | 1 | Descriptor present |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_kind | output | 2 | 0 dropped prefix, 1 main, 2 extended, 3 bit page |
| out_index | output | 2 | 0 none, 1 first index register, 2 second |
| out_opcode | output | 8 | Final opcode byte, or the dropped prefix byte |
| out_mem_idx | output | 1 | HL memory operand becomes indexed |
| out_has_disp | output | 1 | out_disp carries a displacement |
| out_disp | output | 8 | Displacement byte |
| out_disp_first | output | 1 | Displacement preceded the opcode |
| out_reg_sub | output | 1 | H, L and HL register references use the index register |

## Verification
The bench builds the decoder with its default prefix codes: 0xDD and 0xFD for the index registers, 0xED for the extended page and 0xCB for the bit page. With these codes, the stimulus table can be written directly as fetch-order byte streams. It covers prefix chains of one to four bytes, the cancelling of an index prefix by the extended page, and the displacement-first ordering on the bit page. Directed tests then hold the consumer stalled across a second byte and assert reset while a prefix is pending.

// File: rtl/index_prefix_decoder.sv
module index_prefix_decoder #(
  parameter logic [7:0] PFX_X   = 8'hDD,
  parameter logic [7:0] PFX_Y   = 8'hFD,
  parameter logic [7:0] PFX_EXT = 8'hED,
  parameter logic [7:0] PFX_BIT = 8'hCB
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_kind,
  output logic [1:0] out_index,
  output logic [7:0] out_opcode,
  output logic       out_mem_idx,
  output logic       out_has_disp,
  output logic [7:0] out_disp,
  output logic       out_disp_first,
  output logic       out_reg_sub
);

  localparam logic [1:0] K_DROP = 2'd0, K_MAIN = 2'd1, K_EXT = 2'd2, K_BIT = 2'd3;
  localparam logic [1:0] IX_NONE = 2'd0, IX_X = 2'd1, IX_Y = 2'd2;

  typedef enum logic [2:0] {
    ST_BASE, ST_IDX, ST_EXT, ST_BIT, ST_XBIT_D, ST_XBIT_OP, ST_DISP
  } st_t;

  st_t        st, st_n;
  logic [1:0] idx, idx_n;
  logic [7:0] hold_op, hold_op_n;
  logic [7:0] hold_d, hold_d_n;

  logic       emit;
  logic [1:0] e_kind, e_index;
  logic [7:0] e_op, e_disp;
  logic       e_mem, e_hd, e_df, e_rs;

  logic take, is_idx_pfx;
  logic [1:0] pfx_code;
  logic [7:0] cur_pfx;

  function automatic logic mem_form(input logic [7:0] b);
    case (b[7:6])
      2'b01:   mem_form = (b[5:3] == 3'd6 || b[2:0] == 3'd6) && b != 8'h76;
      2'b10:   mem_form = (b[2:0] == 3'd6);
      2'b00:   mem_form = (b == 8'h34 || b == 8'h35 || b == 8'h36);
      default: mem_form = 1'b0;
    endcase
  endfunction

  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;
  assign is_idx_pfx = (in_byte == PFX_X) || (in_byte == PFX_Y);
  assign pfx_code   = (in_byte == PFX_X) ? IX_X : IX_Y;
  assign cur_pfx    = (idx == IX_X) ? PFX_X : PFX_Y;

  always_comb begin
    st_n      = st;
    idx_n     = idx;
    hold_op_n = hold_op;
    hold_d_n  = hold_d;
    emit      = 1'b0;
    e_kind    = K_MAIN;
    e_index   = IX_NONE;
    e_op      = in_byte;
    e_disp    = 8'h00;
    e_mem     = 1'b0;
    e_hd      = 1'b0;
    e_df      = 1'b0;
    e_rs      = 1'b0;
    case (st)
      ST_BASE: begin
        if (is_idx_pfx) begin
          st_n  = ST_IDX;
          idx_n = pfx_code;
        end else if (in_byte == PFX_EXT) begin
          st_n = ST_EXT;
        end else if (in_byte == PFX_BIT) begin
          st_n = ST_BIT;
        end else begin
          emit = 1'b1;
        end
      end
      ST_IDX: begin
        if (is_idx_pfx) begin
          emit   = 1'b1;
          e_kind = K_DROP;
          e_op   = cur_pfx;
          idx_n  = pfx_code;
        end else if (in_byte == PFX_EXT) begin
          emit   = 1'b1;
          e_kind = K_DROP;
          e_op   = cur_pfx;
          idx_n  = IX_NONE;
          st_n   = ST_EXT;
        end else if (in_byte == PFX_BIT) begin
          st_n = ST_XBIT_D;
        end else if (mem_form(in_byte)) begin
          hold_op_n = in_byte;
          st_n      = ST_DISP;
        end else begin
          emit    = 1'b1;
          e_index = idx;
          e_rs    = (in_byte != 8'hEB) && (in_byte != 8'hD9);
          idx_n   = IX_NONE;
          st_n    = ST_BASE;
        end
      end
      ST_EXT: begin
        emit   = 1'b1;
        e_kind = K_EXT;
        st_n   = ST_BASE;
      end
      ST_BIT: begin
        emit   = 1'b1;
        e_kind = K_BIT;
        st_n   = ST_BASE;
      end
      ST_XBIT_D: begin
        hold_d_n = in_byte;
        st_n     = ST_XBIT_OP;
      end
      ST_XBIT_OP: begin
        emit    = 1'b1;
        e_kind  = K_BIT;
        e_index = idx;
        e_mem   = 1'b1;
        e_hd    = 1'b1;
        e_df    = 1'b1;
        e_disp  = hold_d;
        idx_n   = IX_NONE;
        st_n    = ST_BASE;
      end
      ST_DISP: begin
        emit    = 1'b1;
        e_index = idx;
        e_op    = hold_op;
        e_mem   = 1'b1;
        e_hd    = 1'b1;
        e_disp  = in_byte;
        idx_n   = IX_NONE;
        st_n    = ST_BASE;
      end
      default: begin
        st_n  = ST_BASE;
        idx_n = IX_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_BASE;
      idx     <= IX_NONE;
      hold_op <= 8'h00;
      hold_d  <= 8'h00;
    end else if (take) begin
      st      <= st_n;
      idx     <= idx_n;
      hold_op <= hold_op_n;
      hold_d  <= hold_d_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_kind       <= K_DROP;
      out_index      <= IX_NONE;
      out_opcode     <= 8'h00;
      out_mem_idx    <= 1'b0;
      out_has_disp   <= 1'b0;
      out_disp       <= 8'h00;
      out_disp_first <= 1'b0;
      out_reg_sub    <= 1'b0;
    end else if (take && emit) begin
      out_valid      <= 1'b1;
      out_kind       <= e_kind;
      out_index      <= e_index;
      out_opcode     <= e_op;
      out_mem_idx    <= e_mem;
      out_has_disp   <= e_hd;
      out_disp       <= e_disp;
      out_disp_first <= e_df;
      out_reg_sub    <= e_rs;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_drop_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == K_DROP |->
      out_index == IX_NONE && !out_mem_idx && !out_has_disp &&
      (out_opcode == PFX_X || out_opcode == PFX_Y));

  assert_mem_has_disp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mem_idx |-> out_has_disp && out_index != IX_NONE);

  assert_sub_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_reg_sub |-> !out_mem_idx && out_kind == K_MAIN);

  assert_ext_unindexed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == K_EXT |-> out_index == IX_NONE && !out_reg_sub && !out_mem_idx);

  assert_disp_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_disp_first |-> out_kind == K_BIT && out_mem_idx && out_index != IX_NONE);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_opcode) && $stable(out_kind) && $stable(out_disp));

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: tb/test_index_prefix_decoder.sv
`timescale 1ns/1ps
module test_index_prefix_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = 8'h00;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_kind, out_index;
  logic [7:0] out_opcode, out_disp;
  logic out_mem_idx, out_has_disp, out_disp_first, out_reg_sub;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  index_prefix_decoder i_index_prefix_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_index(out_index),
    .out_opcode(out_opcode), .out_mem_idx(out_mem_idx), .out_has_disp(out_has_disp),
    .out_disp(out_disp), .out_disp_first(out_disp_first), .out_reg_sub(out_reg_sub));

  // req[36:33] byte[32:25] valid[24] kind idx op mem hd disp df rs [23:0]
  function automatic logic [36:0] ev(input logic [3:0] r, input logic [7:0] b,
      input logic [1:0] k, input logic [1:0] i, input logic [7:0] op, input logic m,
      input logic hd, input logic [7:0] d, input logic df, input logic rs);
    ev = {r, b, 1'b1, k, i, op, m, hd, d, df, rs};
  endfunction

  function automatic logic [36:0] nb(input logic [3:0] r, input logic [7:0] b);
    nb = {r, b, 1'b0, 24'h0};
  endfunction

  localparam int N = 56;
  localparam logic [36:0] VEC [N] = '{
    ev(2, 8'h00, 1, 0, 8'h00, 0, 0, 8'h00, 0, 0),  // R2
    ev(2, 8'h7E, 1, 0, 8'h7E, 0, 0, 8'h00, 0, 0),  // R2
    nb(4, 8'hDD),                                   // R4
    nb(4, 8'h7E),
    ev(4, 8'h05, 1, 1, 8'h7E, 1, 1, 8'h05, 0, 0),
    nb(5, 8'hFD),                                   // R5 with a chain of two
    ev(5, 8'hFD, 0, 0, 8'hFD, 0, 0, 8'h00, 0, 0),
    nb(5, 8'h66),
    ev(5, 8'hFF, 1, 2, 8'h66, 1, 1, 8'hFF, 0, 0),
    nb(3, 8'hDD),                                   // R3 chain of four
    ev(3, 8'hFD, 0, 0, 8'hDD, 0, 0, 8'h00, 0, 0),
    ev(3, 8'hDD, 0, 0, 8'hFD, 0, 0, 8'h00, 0, 0),
    ev(3, 8'hDD, 0, 0, 8'hDD, 0, 0, 8'h00, 0, 0),
    nb(3, 8'h74),
    ev(3, 8'h80, 1, 1, 8'h74, 1, 1, 8'h80, 0, 0),
    nb(6, 8'hFD),                                   // R6
    ev(6, 8'h21, 1, 2, 8'h21, 0, 0, 8'h00, 0, 1),
    nb(6, 8'hDD),
    ev(6, 8'hEB, 1, 1, 8'hEB, 0, 0, 8'h00, 0, 0),
    nb(6, 8'hFD),
    ev(6, 8'hD9, 1, 2, 8'hD9, 0, 0, 8'h00, 0, 0),
    nb(7, 8'hDD),                                   // R7
    ev(7, 8'hED, 0, 0, 8'hDD, 0, 0, 8'h00, 0, 0),
    ev(7, 8'h44, 2, 0, 8'h44, 0, 0, 8'h00, 0, 0),
    nb(8, 8'hED),                                   // R8
    ev(8, 8'hDD, 2, 0, 8'hDD, 0, 0, 8'h00, 0, 0),
    nb(8, 8'hED),
    ev(8, 8'hCB, 2, 0, 8'hCB, 0, 0, 8'h00, 0, 0),
    nb(9, 8'hCB),                                   // R9
    ev(9, 8'h06, 3, 0, 8'h06, 0, 0, 8'h00, 0, 0),
    nb(10, 8'hDD),                                  // R10
    nb(10, 8'hCB),
    nb(10, 8'h01),
    ev(10, 8'h00, 3, 1, 8'h00, 1, 1, 8'h01, 1, 0),
    nb(10, 8'hFD),
    nb(10, 8'hCB),
    nb(10, 8'h10),
    ev(10, 8'h46, 3, 2, 8'h46, 1, 1, 8'h10, 1, 0),
    ev(11, 8'h24, 1, 0, 8'h24, 0, 0, 8'h00, 0, 0), // R11
    nb(4, 8'hDD),                                   // R4
    nb(4, 8'h36),
    ev(4, 8'h05, 1, 1, 8'h36, 1, 1, 8'h05, 0, 0),
    nb(3, 8'hFD),                                   // R3 chain of three
    ev(3, 8'hFD, 0, 0, 8'hFD, 0, 0, 8'h00, 0, 0),
    ev(3, 8'hFD, 0, 0, 8'hFD, 0, 0, 8'h00, 0, 0),
    nb(3, 8'h34),
    ev(3, 8'h02, 1, 2, 8'h34, 1, 1, 8'h02, 0, 0),
    nb(6, 8'hDD),                                   // R6
    ev(6, 8'hE9, 1, 1, 8'hE9, 0, 0, 8'h00, 0, 1),
    nb(7, 8'hFD),                                   // R7
    ev(7, 8'hED, 0, 0, 8'hFD, 0, 0, 8'h00, 0, 0),
    ev(7, 8'hB0, 2, 0, 8'hB0, 0, 0, 8'h00, 0, 0),
    nb(4, 8'hDD),                                   // R4
    nb(4, 8'h86),
    ev(4, 8'hFE, 1, 1, 8'h86, 1, 1, 8'hFE, 0, 0),
    ev(2, 8'h76, 1, 0, 8'h76, 0, 0, 8'h00, 0, 0)   // R2
  };

  function automatic logic [23:0] got();
    got = {out_kind, out_index, out_opcode, out_mem_idx, out_has_disp,
           out_disp, out_disp_first, out_reg_sub};
  endfunction

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic feed(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {23'b0, out_valid, in_ready}, {23'b0, 1'b0, 1'b1});
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      feed(VEC[i][32:25]);
      if (VEC[i][24])
        check($sformatf("R%0d step %0d", VEC[i][36:33], i), {out_valid, got()}, VEC[i][24:0]);
      else
        check($sformatf("R%0d step %0d", VEC[i][36:33], i), {24'b0, out_valid}, 25'b0);
    end
    in_valid = 1'b0;
    @(negedge clk);

    // R12: stalled consumer holds the descriptor and blocks input
    out_ready = 1'b0;
    feed(8'h00);
    check("R12", {out_valid, got()}, {1'b1, 2'd1, 2'd0, 8'h00, 12'h0});
    check("R12", {23'b0, in_ready, out_valid}, {23'b0, 1'b0, 1'b1});
    feed(8'h3C);
    check("R12", {out_valid, got()}, {1'b1, 2'd1, 2'd0, 8'h00, 12'h0});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R12", {out_valid, got()}, {1'b1, 2'd1, 2'd0, 8'h3C, 12'h0});
    in_valid = 1'b0;
    @(negedge clk);

    // R1 / R11: reset with a prefix pending clears it
    feed(8'hDD);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", {23'b0, out_valid, in_ready}, {23'b0, 1'b0, 1'b1});
    rst_n = 1'b1;
    feed(8'h7E);
    check("R1", {out_valid, got()}, {1'b1, 2'd1, 2'd0, 8'h7E, 12'h0});
    in_valid = 1'b0;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule